// File: doc/BRIEF.md
# Cross-Domain Register Synchronizer With Busy Flags

This block is the bus-side control for a peripheral whose core runs on its own clock, unrelated to the register-bus clock. Software writes registers over an APB-style interface. Writes to a control register, to the enable bit and to a software-reset bit are carried into the core clock domain. Each crossing uses a toggle request and acknowledge pair, with two-flop synchronizers in both directions. A read-only status word shows which crossings are still in flight.

While a crossing is in flight, new writes to its register are dropped. A small bank of configuration registers stays in the bus domain and drives the core directly. That bank can only be written while the peripheral is disabled, so software sets it up first and sets the enable bit last.

A software reset returns every register in both domains to zero. The reset bit never holds a value on the bus side. Its busy flag stays up until the core has reset and that fact has come back across. While that flag is up, the rest of the map is locked. Blocked writes finish normally on the bus, with no error.

Top module: `xdom_regsync`

## Requirements
- R1: After reset, every register reads 0, the status word is 0, and the core-side enable and control outputs are 0.
- R2: The status word at address 0xE8 holds three flags: bit 0 for software reset, bit 1 for enable and bit 2 for the control register. All other bits read 0, and writes to this address have no effect.
- R3: A write to the control register at 0x04 (8 bits) sets status bit 2 starting with the next read. Once the flag clears, the written value reads back and appears on the core-side control output.
- R4: While status bit 2 is set, writes to the control register are dropped.
- R5: Writing 0x00 with bit 1 set and bit 0 clear sets status bit 1. Once the flag clears, bit 1 of 0x00 reads 1 and the core-side enable output is 1.
- R6: While status bit 1 is set, writes to the enable bit are dropped.
- R7: The configuration registers sit at 0x10 + 4*i (8 bits each) and appear together on the core-side configuration output, entry i at bits [8i+7:8i]. They accept writes only while the enable bit is 0. Writes made while it is 1 leave them unchanged.
- R8: Writing 0x00 with bit 0 set starts a software reset and sets status bit 0. Bit 0 of 0x00 always reads 0. When the flag clears, every register and every core-side output is 0.
- R9: While status bit 0 is set, writes to every address are dropped. Reads of any address other than 0x00 and 0xE8 return 0.
- R10: A single write to 0x00 that sets both bit 0 and bit 1 starts only the software reset. The enable flag is not raised, and the enable bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Register bus clock |
| presetn | input | 1 | Bus-domain asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| gclk | input | 1 | Core clock |
| gresetn | input | 1 | Core-domain asynchronous reset, active low |
| coreEnable | output | 1 | Enable as seen by the core |
| coreCtrlB | output | 8 | Control register as seen by the core |
| coreCfg | output | 32 | Configuration bank, entry i at bits [8i+7:8i] |

## Verification
Two functions can fall in the same cycle: a software reset and an enable update. This happens when one write to 0x00 carries both bits. It can also happen when two requests reach the core on the same core edge. The bench provokes the first case directly with a single write of 0x3. It judges the result by the status word, which must show only the reset flag. After the flag clears, the enable bit and the core enable output must both read 0. The bench also places writes and reads inside the software-reset window and checks that nothing gets through, including a control write that would otherwise reach the core after its reset.

// File: rtl/xdom_regsync_pkg.sv
package xdom_regsync_pkg;
  localparam int CH_SWRST  = 0;
  localparam int CH_ENABLE = 1;
  localparam int CH_CTRLB  = 2;
  localparam int NUM_CH    = 3;

  typedef struct packed {
    logic wrSwrst;
    logic wrEnable;
    logic wrCtrlB;
    logic wrCfg;
    logic swrstDone;
  } strobe_t;
endpackage

// File: rtl/xdom_sync2.sv
module xdom_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xdom_bus_ctrl.sv
module xdom_bus_ctrl
  import xdom_regsync_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CFG    = 4,
  parameter int CTRLA_ADDR = 'h00,
  parameter int CTRLB_ADDR = 'h04,
  parameter int CFG_BASE   = 'h10
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              swrstBit,
  input  logic              enableQ,
  input  logic [NUM_CH-1:0] ackTgl,
  output strobe_t           strobe,
  output logic [NUM_CH-1:0] reqTgl,
  output logic [NUM_CH-1:0] busy
);
  localparam int CFG_END = CFG_BASE + 4 * NUM_CFG;

  logic [NUM_CH-1:0] ackSync;
  logic              swrstAckSeen;
  logic              wr, hitCtrlA, hitCtrlB, hitCfg;

  xdom_sync2 #(.WIDTH(NUM_CH)) uAckSync (
    .clk(pclk), .rstN(presetn), .d(ackTgl), .q(ackSync)
  );

  assign wr       = psel & penable & pwrite;
  assign hitCtrlA = (paddr == ADDR_W'(CTRLA_ADDR));
  assign hitCtrlB = (paddr == ADDR_W'(CTRLB_ADDR));
  assign hitCfg   = (int'(paddr) >= CFG_BASE) && (int'(paddr) < CFG_END) &&
                    (paddr[1:0] == 2'b00);

  // Reset flag drops one cycle after its ack lands, on the edge the
  // bus-side copies are cleared.
  assign busy[CH_SWRST]  = reqTgl[CH_SWRST] ^ swrstAckSeen;
  assign busy[CH_ENABLE] = reqTgl[CH_ENABLE] ^ ackSync[CH_ENABLE];
  assign busy[CH_CTRLB]  = reqTgl[CH_CTRLB] ^ ackSync[CH_CTRLB];

  always_comb begin
    strobe.wrSwrst   = wr & hitCtrlA & swrstBit & ~busy[CH_SWRST];
    strobe.wrEnable  = wr & hitCtrlA & ~swrstBit & ~busy[CH_SWRST] & ~busy[CH_ENABLE];
    strobe.wrCtrlB   = wr & hitCtrlB & ~busy[CH_SWRST] & ~busy[CH_CTRLB];
    strobe.wrCfg     = wr & hitCfg & ~busy[CH_SWRST] & ~enableQ;
    strobe.swrstDone = ackSync[CH_SWRST] ^ swrstAckSeen;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      reqTgl       <= '0;
      swrstAckSeen <= 1'b0;
    end else begin
      swrstAckSeen        <= ackSync[CH_SWRST];
      reqTgl[CH_SWRST]    <= reqTgl[CH_SWRST] ^ strobe.wrSwrst;
      reqTgl[CH_ENABLE]   <= reqTgl[CH_ENABLE] ^ strobe.wrEnable;
      reqTgl[CH_CTRLB]    <= reqTgl[CH_CTRLB] ^ strobe.wrCtrlB;
    end
  end
endmodule

// File: rtl/xdom_bus_regs.sv
module xdom_bus_regs
  import xdom_regsync_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CTRLB_W     = 8,
  parameter int NUM_CFG     = 4,
  parameter int CFG_W       = 8,
  parameter int CTRLA_ADDR  = 'h00,
  parameter int CTRLB_ADDR  = 'h04,
  parameter int CFG_BASE    = 'h10,
  parameter int STATUS_ADDR = 'hE8
) (
  input  logic                         pclk,
  input  logic                         presetn,
  input  strobe_t                      strobe,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [DATA_W-1:0]            pwdata,
  input  logic [NUM_CH-1:0]            busy,
  output logic                         enableQ,
  output logic [CTRLB_W-1:0]           ctrlBQ,
  output logic [NUM_CFG-1:0][CFG_W-1:0] cfgQ,
  output logic [DATA_W-1:0]            rdData
);
  localparam int W_MAX = (CTRLB_W > CFG_W) ? CTRLB_W : CFG_W;

  logic unusedBits;
  assign unusedBits = ^{pwdata[DATA_W-1:W_MAX], strobe.wrSwrst};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      enableQ <= 1'b0;
      ctrlBQ  <= '0;
      cfgQ    <= '0;
    end else if (strobe.swrstDone) begin
      enableQ <= 1'b0;
      ctrlBQ  <= '0;
      cfgQ    <= '0;
    end else begin
      if (strobe.wrEnable) enableQ <= pwdata[1];
      if (strobe.wrCtrlB)  ctrlBQ  <= pwdata[CTRLB_W-1:0];
      for (int i = 0; i < NUM_CFG; i++) begin
        if (strobe.wrCfg && paddr == ADDR_W'(CFG_BASE + 4 * i))
          cfgQ[i] <= pwdata[CFG_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (paddr == ADDR_W'(STATUS_ADDR)) begin
      rdData[NUM_CH-1:0] = busy;
    end else if (paddr == ADDR_W'(CTRLA_ADDR)) begin
      rdData[1] = enableQ;
    end else if (!busy[CH_SWRST]) begin
      if (paddr == ADDR_W'(CTRLB_ADDR)) rdData[CTRLB_W-1:0] = ctrlBQ;
      for (int i = 0; i < NUM_CFG; i++) begin
        if (paddr == ADDR_W'(CFG_BASE + 4 * i)) rdData[CFG_W-1:0] = cfgQ[i];
      end
    end
  end
endmodule

// File: rtl/xdom_core_side.sv
module xdom_core_side
  import xdom_regsync_pkg::*;
#(
  parameter int CTRLB_W = 8
) (
  input  logic               gclk,
  input  logic               gresetn,
  input  logic [NUM_CH-1:0]  reqTgl,
  input  logic               enableQ,
  input  logic [CTRLB_W-1:0] ctrlBQ,
  output logic [NUM_CH-1:0]  ackTgl,
  output logic               coreEnable,
  output logic [CTRLB_W-1:0] coreCtrlB
);
  logic [NUM_CH-1:0] reqSync, reqSeen, reqEdge;

  xdom_sync2 #(.WIDTH(NUM_CH)) uReqSync (
    .clk(gclk), .rstN(gresetn), .d(reqTgl), .q(reqSync)
  );

  assign reqEdge = reqSync ^ reqSeen;
  assign ackTgl  = reqSeen;

  always_ff @(posedge gclk or negedge gresetn) begin
    if (!gresetn) begin
      reqSeen    <= '0;
      coreEnable <= 1'b0;
      coreCtrlB  <= '0;
    end else begin
      reqSeen <= reqSync;
      if (reqEdge[CH_SWRST]) begin
        coreEnable <= 1'b0;
        coreCtrlB  <= '0;
      end else begin
        if (reqEdge[CH_ENABLE]) coreEnable <= enableQ;
        if (reqEdge[CH_CTRLB])  coreCtrlB  <= ctrlBQ;
      end
    end
  end
endmodule

// File: rtl/xdom_regsync.sv
module xdom_regsync
  import xdom_regsync_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CTRLB_W     = 8,
  parameter int NUM_CFG     = 4,
  parameter int CFG_W       = 8,
  parameter int CTRLA_ADDR  = 'h00,
  parameter int CTRLB_ADDR  = 'h04,
  parameter int CFG_BASE    = 'h10,
  parameter int STATUS_ADDR = 'hE8,
  localparam int CFG_BITS   = NUM_CFG * CFG_W
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  output logic [DATA_W-1:0]   prdata,
  input  logic                gclk,
  input  logic                gresetn,
  output logic                coreEnable,
  output logic [CTRLB_W-1:0]  coreCtrlB,
  output logic [CFG_BITS-1:0] coreCfg
);
  strobe_t                      strobe;
  logic [NUM_CH-1:0]            reqTgl, ackTgl, busy;
  logic                         enableQ;
  logic [CTRLB_W-1:0]           ctrlBQ;
  logic [NUM_CFG-1:0][CFG_W-1:0] cfgQ;

  assign coreCfg = cfgQ;

  xdom_bus_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .CTRLA_ADDR(CTRLA_ADDR),
    .CTRLB_ADDR(CTRLB_ADDR), .CFG_BASE(CFG_BASE)
  ) uCtrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .swrstBit(pwdata[0]),
    .enableQ(enableQ), .ackTgl(ackTgl), .strobe(strobe),
    .reqTgl(reqTgl), .busy(busy)
  );

  xdom_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRLB_W(CTRLB_W), .NUM_CFG(NUM_CFG),
    .CFG_W(CFG_W), .CTRLA_ADDR(CTRLA_ADDR), .CTRLB_ADDR(CTRLB_ADDR),
    .CFG_BASE(CFG_BASE), .STATUS_ADDR(STATUS_ADDR)
  ) uRegs (
    .pclk(pclk), .presetn(presetn), .strobe(strobe), .paddr(paddr),
    .pwdata(pwdata), .busy(busy), .enableQ(enableQ), .ctrlBQ(ctrlBQ),
    .cfgQ(cfgQ), .rdData(prdata)
  );

  xdom_core_side #(.CTRLB_W(CTRLB_W)) uCore (
    .gclk(gclk), .gresetn(gresetn), .reqTgl(reqTgl), .enableQ(enableQ),
    .ctrlBQ(ctrlBQ), .ackTgl(ackTgl), .coreEnable(coreEnable),
    .coreCtrlB(coreCtrlB)
  );
endmodule

// File: rtl/xdom_regsync_chk.sv
module xdom_regsync_chk
  import xdom_regsync_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CFG_BITS    = 32,
  parameter int CTRLA_ADDR  = 'h00,
  parameter int STATUS_ADDR = 'hE8
) (
  input logic                pclk,
  input logic                presetn,
  input logic                psel,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   prdata,
  input strobe_t             strobe,
  input logic [NUM_CH-1:0]   busy,
  input logic                enableQ,
  input logic [CFG_BITS-1:0] coreCfg
);
  logic unusedChk;
  assign unusedChk = strobe.wrCfg;

  // R2: status word carries exactly the busy flags
  p_status_word_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr == ADDR_W'(STATUS_ADDR)) |->
      (prdata[DATA_W-1:NUM_CH] == '0 && prdata[NUM_CH-1:0] == busy));

  p_ctrlb_busy_set_r3: assert property (@(posedge pclk) disable iff (!presetn)
    strobe.wrCtrlB |=> busy[CH_CTRLB]);

  p_ctrlb_no_wr_busy_r4: assert property (@(posedge pclk) disable iff (!presetn)
    busy[CH_CTRLB] |-> !strobe.wrCtrlB);

  p_enable_no_wr_busy_r6: assert property (@(posedge pclk) disable iff (!presetn)
    busy[CH_ENABLE] |-> !strobe.wrEnable);

  p_cfg_locked_r7: assert property (@(posedge pclk) disable iff (!presetn)
    enableQ |=> (!enableQ || $stable(coreCfg)));

  p_swrst_busy_set_r8: assert property (@(posedge pclk) disable iff (!presetn)
    strobe.wrSwrst |=> busy[CH_SWRST]);

  p_swrst_clears_enable_r8: assert property (@(posedge pclk) disable iff (!presetn)
    strobe.swrstDone |=> !enableQ);

  p_blocked_read_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (busy[CH_SWRST] && psel && paddr != ADDR_W'(CTRLA_ADDR) &&
     paddr != ADDR_W'(STATUS_ADDR)) |-> prdata == '0);

  p_reset_wins_r10: assert property (@(posedge pclk) disable iff (!presetn)
    strobe.wrSwrst |-> !strobe.wrEnable);
endmodule

bind xdom_regsync xdom_regsync_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BITS(CFG_BITS),
  .CTRLA_ADDR(CTRLA_ADDR), .STATUS_ADDR(STATUS_ADDR)
) uChk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .paddr(paddr),
  .prdata(prdata), .strobe(strobe), .busy(busy), .enableQ(enableQ),
  .coreCfg(coreCfg)
);

// File: tb/xdom_regsync_test.sv
`timescale 1ns/1ps
module xdom_regsync_test;
  localparam logic [7:0] A_CTRLA  = 8'h00;
  localparam logic [7:0] A_CTRLB  = 8'h04;
  localparam logic [7:0] A_CFG0   = 8'h10;
  localparam logic [7:0] A_CFG3   = 8'h1C;
  localparam logic [7:0] A_STATUS = 8'hE8;

  logic        pclk = 1'b0, gclk = 1'b0;
  logic        presetn = 1'b0, gresetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        coreEnable;
  logic [7:0]  coreCtrlB;
  logic [31:0] coreCfg;

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t expQ[$];
  item_t actQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 pclk = ~pclk;     // 50 MHz bus clock
  always #26.5 gclk = ~gclk;   // unrelated core clock

  xdom_regsync uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .gclk(gclk), .gresetn(gresetn), .coreEnable(coreEnable),
    .coreCtrlB(coreCtrlB), .coreCfg(coreCfg)
  );

  // Monitor: pops expected and observed items and compares them.
  always @(negedge pclk) begin
    while (expQ.size() > 0 && actQ.size() > 0) begin
      item_t e, a;
      e = expQ.pop_front();
      a = actQ.pop_front();
      checks++;
      if (a.val !== e.val) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", e.tag, a.val, e.val);
      end
    end
  end

  // Bus tasks: called at a falling edge, return at a falling edge.
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #5 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expectRead(input string tag, input logic [7:0] a,
                            input logic [31:0] expv);
    logic [31:0] d;
    expQ.push_back('{tag, expv});
    busRead(a, d);
    actQ.push_back('{tag, d});
  endtask

  task automatic expectPort(input string tag, input logic [31:0] actv,
                            input logic [31:0] expv);
    expQ.push_back('{tag, expv});
    actQ.push_back('{tag, actv});
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] d;
    d = 32'hFFFF_FFFF;
    for (int n = 0; n < 100 && d != 0; n++) busRead(A_STATUS, d);
    if (d != 0) expectPort(tag, d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1; gresetn = 1'b1;
    @(negedge pclk);

    // R1: reset state
    expectRead("R1 status", A_STATUS, 32'h0);
    expectRead("R1 ctrlA", A_CTRLA, 32'h0);
    expectRead("R1 ctrlB", A_CTRLB, 32'h0);
    expectRead("R1 cfg3", A_CFG3, 32'h0);
    expectPort("R1 coreEnable", {31'b0, coreEnable}, 32'h0);
    expectPort("R1 coreCtrlB", {24'b0, coreCtrlB}, 32'h0);

    // R7: configuration writable while disabled
    busWrite(A_CFG0, 32'h11);
    busWrite(A_CFG3, 32'h44);
    expectRead("R7 cfg0 written", A_CFG0, 32'h11);
    expectRead("R7 cfg3 written", A_CFG3, 32'h44);
    expectPort("R7 coreCfg", coreCfg, 32'h4400_0011);

    // R3 / R4: control write, second write while busy is dropped
    busWrite(A_CTRLB, 32'hA5);
    busWrite(A_CTRLB, 32'h3C);
    expectRead("R3 busy bit2", A_STATUS, 32'h4);
    waitIdle("R3 idle");
    expectRead("R4 ctrlB kept first value", A_CTRLB, 32'hA5);
    expectPort("R3 coreCtrlB", {24'b0, coreCtrlB}, 32'hA5);

    // R5 / R6: enable write, clear while busy is dropped
    busWrite(A_CTRLA, 32'h2);
    busWrite(A_CTRLA, 32'h0);
    expectRead("R5 busy bit1", A_STATUS, 32'h2);
    waitIdle("R5 idle");
    expectRead("R6 enable kept", A_CTRLA, 32'h2);
    expectPort("R5 coreEnable", {31'b0, coreEnable}, 32'h1);

    // R7: locked while enabled
    busWrite(A_CFG0, 32'h99);
    expectRead("R7 cfg0 locked", A_CFG0, 32'h11);
    expectPort("R7 coreCfg locked", coreCfg, 32'h4400_0011);

    // R2: status is read-only
    busWrite(A_STATUS, 32'hFFFF_FFFF);
    expectRead("R2 status unwritable", A_STATUS, 32'h0);

    // R8 / R9: software reset sequence
    busWrite(A_CTRLA, 32'h1);
    expectRead("R8 busy bit0", A_STATUS, 32'h1);
    expectRead("R8 swrst bit reads 0", A_CTRLA, 32'h2);
    expectRead("R9 cfg0 read blocked", A_CFG0, 32'h0);
    busWrite(A_CTRLB, 32'h5A);
    waitIdle("R8 idle");
    expectRead("R8 ctrlA cleared", A_CTRLA, 32'h0);
    expectRead("R9 ctrlB write dropped", A_CTRLB, 32'h0);
    expectRead("R8 cfg0 cleared", A_CFG0, 32'h0);
    expectRead("R8 cfg3 cleared", A_CFG3, 32'h0);
    expectPort("R8 coreEnable", {31'b0, coreEnable}, 32'h0);
    expectPort("R9 coreCtrlB", {24'b0, coreCtrlB}, 32'h0);
    expectPort("R8 coreCfg", coreCfg, 32'h0);

    // R10: reset and enable in one write
    busWrite(A_CTRLA, 32'h3);
    expectRead("R10 only reset busy", A_STATUS, 32'h1);
    waitIdle("R10 idle");
    expectRead("R10 enable 0", A_CTRLA, 32'h0);
    expectPort("R10 coreEnable", {31'b0, coreEnable}, 32'h0);

    // R3: second pattern after reset
    busWrite(A_CTRLB, 32'h0F);
    waitIdle("R3 idle2");
    expectRead("R3 ctrlB second", A_CTRLB, 32'h0F);
    expectPort("R3 coreCtrlB second", {24'b0, coreCtrlB}, 32'h0F);

    repeat (3) @(negedge pclk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule